// File: doc/BRIEF.md
# Multi-Source Reset Combiner with Strap Capture

This block merges three reset requests into one synchronous reset for a processor core and its peripherals. The three requests are an active-low board reset pin, a power-on-delay busy flag and a single-cycle watchdog expiry pulse. The board pin is raw and asynchronous, so it passes through a flop synchronizer on the bus clock. A watchdog pulse is stretched to a fixed minimum length. All active requests then feed a set-dominant register whose output is the system reset.

The block also holds the operating-mode value. It copies this value from the mode strap pins only when a reset ends that was raised by the board pin or the watchdog. When a reset ends that came only from the power-on delay, the stored mode is left alone. The power-on-delay flag also acts as the block's own startup initializer. While it is high, the reset output is forced high at once and the mode falls back to its default value. There is no data flow through the block, so every pin is plain control and no valid/ready handshake exists.

Top module: `rst_combiner`

## Requirements
- R1: While `por_busy` is 1, `rst_out` is 1 and `mode_q` equals `MODE_DEFAULT` (default 0). Both take effect without waiting for a clock edge.
- R2: The pin `pin_rst_n` is active low and passes through `SYNC_STAGES` (default 2) flops. `rst_out` rises at the third rising edge after the pin is first sampled low. It falls at the third rising edge after the pin is first sampled high, if no other source is active.
- R3: A one-cycle `wdt_pulse` sets `rst_out` at the next rising edge. When nothing else is active, `rst_out` stays 1 for exactly 1 + `WDT_STRETCH` cycles (5 by default).
- R4: `rst_out` never falls while a source is active. It falls at the first rising edge at which no source is active.
- R5: At the edge where a reset ends, `mode_q` loads `mode_pins` as sampled at that edge, if the board pin or the watchdog was active at any time during that reset.
- R6: When a reset ends in which only the power-on delay was active, `mode_q` keeps its value, whatever `mode_pins` shows.
- R7: At all other times `mode_q` does not change. Changes on `mode_pins` during normal running, or partway through a reset, are ignored.
- R8: If the power-on delay ends while the board pin is still held low, `rst_out` stays 1 with no gap. The later release counts as a board-pin reset and loads `mode_pins`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| pin_rst_n | input | 1 | Raw board reset pin, active low, asynchronous |
| por_busy | input | 1 | Power-on delay in progress, active high; also the block's startup initializer |
| wdt_pulse | input | 1 | Watchdog expiry, one cycle, synchronous to `clk` |
| mode_pins | input | MODE_W | Mode strap inputs |
| rst_out | output | 1 | Synchronous system reset, active high |
| mode_q | output | MODE_W | Latched operating mode |

## Verification
A bad reset-cause record does not show up until the reset ends. It then appears at that single release edge: `mode_q` is either reloaded when it should have been kept, or kept when it should have been reloaded. The error then stays on `mode_q` until the next qualifying reset. A wrong synchronizer depth or stretch count shows at `rst_out` as an edge one cycle early or late, on the third cycle after a pin change or after the fifth watchdog cycle. The bench therefore runs a cycle model every cycle and compares both outputs. It also steers directed cases onto exactly those edges.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // Reset cause, encoded so that a larger value has higher priority.
  typedef enum logic [1:0] {
    CZ_NONE = 2'd0,
    CZ_POR  = 2'd1,
    CZ_WDT  = 2'd2,
    CZ_EXT  = 2'd3
  } cause_e;

  function automatic cause_e cause_max(input cause_e a, input cause_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstc_sync.sv
// Flop chain for the raw reset request. The chain has no reset, so it keeps
// tracking the pin while the power-on delay holds the rest of the block.
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sh <= d;
    end else begin : g_many
      always_ff @(posedge clk) sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rstc_wdt_stretch.sv
// Keeps the watchdog request active for the pulse cycle plus STRETCH cycles.
module rstc_wdt_stretch #(
  parameter int STRETCH = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic pulse,
  output logic active
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)               cnt <= '0;
    else if (pulse)         cnt <= LOAD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active = pulse | (cnt != '0);
endmodule

// File: rtl/rstc_latch.sv
// Set-dominant reset register, cause tracking and mode strap capture.
module rstc_latch
  import rstc_pkg::*;
#(
  parameter int                MODE_W       = 2,
  parameter logic [MODE_W-1:0] MODE_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              ext_act,
  input  logic              wdt_act,
  input  logic              por_act,
  input  logic [MODE_W-1:0] mode_pins,
  output logic              rst_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              cap_stb
);
  cause_e cur, cause_q;
  logic   any_src, release_now;

  always_comb begin
    if (ext_act)      cur = CZ_EXT;
    else if (wdt_act) cur = CZ_WDT;
    else if (por_act) cur = CZ_POR;
    else              cur = CZ_NONE;
    any_src     = (cur != CZ_NONE);
    release_now = rst_q && !any_src;
    cap_stb     = release_now && ((cause_q == CZ_EXT) || (cause_q == CZ_WDT));
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      rst_q   <= 1'b1;
      cause_q <= CZ_NONE;
      mode_q  <= MODE_DEFAULT;
    end else begin
      rst_q <= any_src;
      if (any_src) cause_q <= cause_max(rst_q ? cause_q : CZ_NONE, cur);
      else         cause_q <= CZ_NONE;
      if (cap_stb) mode_q <= mode_pins;
    end
  end
endmodule

// File: rtl/rst_combiner.sv
module rst_combiner #(
  parameter int                MODE_W       = 2,
  parameter logic [MODE_W-1:0] MODE_DEFAULT = '0,
  parameter int                SYNC_STAGES  = 2,
  parameter int                WDT_STRETCH  = 4
) (
  input  logic              clk,
  input  logic              pin_rst_n,
  input  logic              por_busy,
  input  logic              wdt_pulse,
  input  logic [MODE_W-1:0] mode_pins,
  output logic              rst_out,
  output logic [MODE_W-1:0] mode_q
);
  logic ext_act, wdt_act, cap_stb;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (~pin_rst_n),
    .q   (ext_act)
  );

  rstc_wdt_stretch #(.STRETCH(WDT_STRETCH)) u_wdt (
    .clk    (clk),
    .arst   (por_busy),
    .pulse  (wdt_pulse),
    .active (wdt_act)
  );

  rstc_latch #(.MODE_W(MODE_W), .MODE_DEFAULT(MODE_DEFAULT)) u_latch (
    .clk       (clk),
    .arst      (por_busy),
    .ext_act   (ext_act),
    .wdt_act   (wdt_act),
    .por_act   (por_busy),
    .mode_pins (mode_pins),
    .rst_q     (rst_out),
    .mode_q    (mode_q),
    .cap_stb   (cap_stb)
  );
endmodule

// File: rtl/rst_combiner_chk.sv
module rst_combiner_chk #(
  parameter int MODE_W      = 2,
  parameter int WDT_STRETCH = 4
) (
  input logic              clk,
  input logic              por_busy,
  input logic              wdt_pulse,
  input logic              ext_act,
  input logic              wdt_act,
  input logic              cap_stb,
  input logic              rst_out,
  input logic [MODE_W-1:0] mode_q
);
  localparam int CW = $clog2(WDT_STRETCH + 2);
  logic [CW-1:0] win;

  // Independent window counter: cycles the reset must still cover after a pulse.
  always_ff @(posedge clk or posedge por_busy) begin
    if (por_busy)       win <= '0;
    else if (wdt_pulse) win <= CW'(WDT_STRETCH + 1);
    else if (win != '0) win <= win - 1'b1;
  end

  assert_src_sets_rst_R4: assert property (@(posedge clk) disable iff (por_busy)
    (ext_act || wdt_act) |=> rst_out);

  assert_fall_only_idle_R4: assert property (@(posedge clk) disable iff (por_busy)
    $fell(rst_out) |-> $past(!ext_act && !wdt_act));

  assert_wdt_min_width_R3: assert property (@(posedge clk) disable iff (por_busy)
    (win != '0) |-> rst_out);

  assert_cap_at_release_R5: assert property (@(posedge clk) disable iff (por_busy)
    cap_stb |-> (rst_out && !ext_act && !wdt_act));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (por_busy)
    !$stable(mode_q) |-> $past(cap_stb));
endmodule

bind rst_combiner rst_combiner_chk #(.MODE_W(MODE_W), .WDT_STRETCH(WDT_STRETCH)) u_chk (
  .clk       (clk),
  .por_busy  (por_busy),
  .wdt_pulse (wdt_pulse),
  .ext_act   (ext_act),
  .wdt_act   (wdt_act),
  .cap_stb   (cap_stb),
  .rst_out   (rst_out),
  .mode_q    (mode_q)
);

// File: tb/rst_combiner_tb.sv
`timescale 1ns/1ps
module rst_combiner_tb;
  localparam int MW  = 2;
  localparam logic [MW-1:0] DEF = '0;
  localparam int STR = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic pin_n = 1'b1, por = 1'b1, wdt = 1'b0;
  logic [MW-1:0] pins = '0;
  logic rst_out;
  logic [MW-1:0] mode_q;

  int n_tests = 0, n_fail = 0;

  rst_combiner #(.MODE_W(MW), .MODE_DEFAULT(DEF), .SYNC_STAGES(2), .WDT_STRETCH(STR)) u_dut (
    .clk(clk), .pin_rst_n(pin_n), .por_busy(por), .wdt_pulse(wdt),
    .mode_pins(pins), .rst_out(rst_out), .mode_q(mode_q)
  );

  // Cycle model written from the requirements.
  logic m_s1, m_s2, m_rst, m_e, m_w;
  logic [2:0] m_cnt;
  logic [MW-1:0] m_mode;

  function automatic logic m_wact(input logic p, input logic [2:0] c);
    return p | (c != 3'd0);
  endfunction
  function automatic logic m_any(input logic s, input logic p, input logic [2:0] c);
    return s | m_wact(p, c);
  endfunction

  always @(posedge clk) begin
    m_s1 <= ~pin_n;
    m_s2 <= m_s1;
  end

  always @(posedge clk or posedge por) begin
    if (por) begin
      m_rst <= 1'b1; m_cnt <= 3'd0; m_e <= 1'b0; m_w <= 1'b0; m_mode <= DEF;
    end else begin
      m_rst <= m_any(m_s2, wdt, m_cnt);
      if (wdt) m_cnt <= 3'(STR);
      else if (m_cnt != 3'd0) m_cnt <= m_cnt - 3'd1;
      if (!m_any(m_s2, wdt, m_cnt)) begin
        m_e <= 1'b0; m_w <= 1'b0;
        if (m_rst && (m_e || m_w)) m_mode <= pins;
      end else if (m_rst) begin
        m_e <= m_e | m_s2; m_w <= m_w | m_wact(wdt, m_cnt);
      end else begin
        m_e <= m_s2; m_w <= m_wact(wdt, m_cnt);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'h1f2e3d4c));
    @(negedge clk);
    repeat (3) tick();
    chk("R1 reset state rst_out", rst_out, 1);
    chk("R1 reset state mode_q", mode_q, DEF);

    // Power-on delay ends alone: release, no capture.
    pins = 2'b10; por = 1'b0;
    tick();
    chk("R4 release after por", rst_out, 0);
    chk("R6 mode kept after por", mode_q, DEF);

    pins = 2'b11;
    repeat (3) tick();
    chk("R7 pins ignored while running", mode_q, DEF);

    // Board pin reset.
    pins = 2'b10; pin_n = 1'b0;
    tick(); tick();
    chk("R2 not yet asserted", rst_out, 0);
    tick();
    chk("R2 asserted third edge", rst_out, 1);
    pin_n = 1'b1;
    tick(); tick();
    chk("R4 held while synced pin active", rst_out, 1);
    tick();
    chk("R2 released third edge", rst_out, 0);
    chk("R5 mode loaded on ext release", mode_q, 2'b10);

    // Watchdog pulse, strap change partway through.
    pins = 2'b01; wdt = 1'b1;
    tick();
    wdt = 1'b0;
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (rst_out) hi++;
      if (i == 1) begin
        chk("R7 mode stable during reset", mode_q, 2'b10);
        pins = 2'b11;
      end
      tick();
    end
    chk("R3 watchdog width", hi, 1 + STR);
    chk("R5 mode loaded on wdt release", mode_q, 2'b11);

    // Mid-run power-on delay.
    por = 1'b1;
    @(negedge clk);
    chk("R1 por forces default", mode_q, DEF);
    chk("R1 por forces reset", rst_out, 1);
    pins = 2'b10; por = 1'b0;
    tick();
    chk("R6 mode kept after mid-run por", mode_q, DEF);

    // Overlap: por ends while pin still low.
    pin_n = 1'b0; por = 1'b1;
    tick(); tick(); tick();
    pins = 2'b11; por = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 no gap after por ends", rst_out, 1);
    end
    pin_n = 1'b1;
    tick(); tick(); tick();
    chk("R8 release", rst_out, 0);
    chk("R8 mode loaded", mode_q, 2'b11);

    // Random phase against the model.
    for (int i = 0; i < 4000; i++) begin
      chk("R4 rst_out vs model", rst_out, m_rst);
      chk("R5 mode_q vs model", mode_q, m_mode);
      if ($urandom % 16 == 0) pin_n = ~pin_n;
      wdt  = ($urandom % 40 == 0);
      por  = ($urandom % 300 == 0);
      pins = MW'($urandom);
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule